// File: doc/BRIEF.md
# Trigger-Matched Multichannel Edge Time Recorder

This block stamps rising hit edges on a set of independent input channels (24 by default) with a time made of a free-running coarse clock count and a sub-clock fine code that arrives with the hit. Each channel parks its stamps in a small private queue. A fixed-priority arbiter moves one stamp per cycle from these queues into a shared latency pipeline, which holds 256 stamps by default. A level-1 trigger pulse captures the current coarse count into a trigger queue that holds up to 8 pending events.

A match engine takes the pending triggers one at a time, oldest first. For each trigger it writes a header word to a 64-entry readout FIFO. It then walks the pipeline from its oldest entry. Stamps that lie inside a programmable window before the trigger time are copied out as data words. Stamps that are too old are discarded. The walk stops at the first stamp that is too recent, and that stamp stays in the pipeline for later triggers. When no trigger is pending, the engine purges stamps that have become too old to match any future trigger.

No output reports a full queue. A lost hit, a lost trigger or a lost data word sets a sticky error bit instead. That bit is carried in the next header written and is then cleared. The match engine runs as a three-state machine:
- `ST_IDLE`: purges stale stamps, and on a pending trigger takes it and moves to `ST_HEAD`.
- `ST_HEAD`: waits for readout space, writes the header, and moves to `ST_SCAN`.
- `ST_SCAN`: walks the pipeline, and returns to `ST_IDLE` on a too-recent stamp, or once the pipeline and all channel queues are empty.

Top module: `tdc_trigmatch_core`

## Requirements
- R1: A data word has kind bits [23:22] = 2'b01, the channel number in [21:17], the 13-bit coarse stamp in [16:4] and the 4-bit fine code in [3:0]. The coarse stamp is the counter value at the clock edge that samples the hit, and the fine code is the one presented with the hit.
- R2: A header word has kind bits [23:22] = 2'b10, the error bit in [21], zeros in [20:13], and in [12:0] the coarse count at the edge that sampled the trigger.
- R3: Let age be (trigger coarse − stamp coarse) mod 2^13. A stamp is output for a trigger when win_lat ≤ age ≤ win_lat + win_width − 1.
- R4: A stamp whose age is at least win_lat + win_width is discarded and never output.
- R5: A stamp younger than the window (age < win_lat) is kept in the pipeline, and a later trigger whose window covers it outputs it.
- R6: Ages are computed modulo 2^13, so a window that spans the coarse counter wraparound still matches.
- R7: Hits sampled on the same edge enter the pipeline lowest channel first, and at most one channel is granted per cycle.
- R8: A hit arriving while its channel queue (4 entries) is full is lost and sets the error bit. The next header reports the bit, and the header after that shows it cleared.
- R9: A trigger arriving while the trigger queue (8 entries) is full is lost and sets the error bit.
- R10: A matched data word that finds the readout FIFO (64 entries) full is lost and sets the error bit. A word at the readout head stays stable while rd_ready is low.
- R11: After reset the readout FIFO is empty (rd_valid low).
- R12: Events are written in trigger order, with each header ahead of its event's data words. Only header and data kinds ever appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_in | input | NUM_CH | Hit edge strobe per channel |
| fine_in | input | NUM_CH*FINE_W | Fine code per channel, packed channel 0 lowest |
| l1_trig | input | 1 | Level-1 trigger strobe |
| win_lat | input | COARSE_W | Window near edge, as age in coarse counts |
| win_width | input | COARSE_W | Window length in coarse counts |
| rd_ready | input | 1 | Pops the readout head when rd_valid is high |
| rd_valid | output | 1 | Readout FIFO not empty |
| rd_data | output | 2+CH_W+COARSE_W+FINE_W | Readout head word |

## Verification
The bench builds the block with its default sizes: 24 channels, 4-entry channel queues, a 256-entry pipeline, an 8-entry trigger queue and a 64-entry readout FIFO. It programs a window of age 8 to 15. With these sizes, flooding every channel for six cycles overruns the highest channel's queue. A burst of 16 triggers overruns the trigger queue, and 72 matched stamps overrun the readout FIFO. Running past 8192 cycles brings the 13-bit counter wraparound into a live window.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_SCAN = 2'd2
    } match_state_t;

    localparam logic [1:0] KIND_HDR  = 2'b10;
    localparam logic [1:0] KIND_DATA = 2'b01;

endpackage

// File: rtl/tdc_sync_fifo.sv
module tdc_sync_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push;
    logic             do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/tdc_prio_arb.sv
module tdc_prio_arb #(
    parameter int N  = 24,
    parameter int IW = 5
) (
    input  logic [N-1:0]  req,
    input  logic          en,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic found;

    always_comb begin
        grant = '0;
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = en;
                idx      = IW'(i);
                found    = 1'b1;
            end
        end
        any = found & en;
    end

endmodule

// File: rtl/tdc_match_fsm.sv
module tdc_match_fsm
    import tdc_pkg::*;
#(
    parameter int CH_W     = 5,
    parameter int COARSE_W = 13,
    parameter int FINE_W   = 4,
    localparam int STAMP_W = COARSE_W + FINE_W,
    localparam int PIPE_W  = CH_W + STAMP_W,
    localparam int OUT_W   = 2 + PIPE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [COARSE_W-1:0] now,
    input  logic [COARSE_W-1:0] win_lat,
    input  logic [COARSE_W-1:0] win_width,
    input  logic                trig_empty,
    input  logic [COARSE_W-1:0] trig_time,
    output logic                trig_pop,
    input  logic                pipe_empty,
    input  logic [PIPE_W-1:0]   pipe_head,
    output logic                pipe_pop,
    input  logic                chbuf_busy,
    input  logic                ro_full,
    input  logic                err_pending,
    output logic                ro_push,
    output logic [OUT_W-1:0]    ro_word,
    output logic                err_clear,
    output logic                ro_lost
);
    match_state_t        state;
    match_state_t        state_nx;
    logic [COARSE_W-1:0] trig_q;
    logic [COARSE_W-1:0] ref_time;
    logic [COARSE_W-1:0] head_coarse;
    logic [COARSE_W-1:0] age;
    logic [COARSE_W:0]   span;
    logic                is_future;
    logic                is_old;
    logic                in_win;

    assign head_coarse = pipe_head[STAMP_W-1:FINE_W];
    assign ref_time    = (state == ST_SCAN) ? trig_q : now;
    assign age         = ref_time - head_coarse;
    assign span        = {1'b0, win_lat} + {1'b0, win_width};
    assign is_future   = age[COARSE_W-1];
    assign is_old      = !is_future && ({1'b0, age} >= span);
    assign in_win      = !is_future && !is_old && (age >= win_lat);

    // state register and latched trigger time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            trig_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && !trig_empty) trig_q <= trig_time;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (!trig_empty) state_nx = ST_HEAD;
            ST_HEAD: if (!ro_full)    state_nx = ST_SCAN;
            ST_SCAN: begin
                if (pipe_empty) begin
                    if (!chbuf_busy) state_nx = ST_IDLE;
                end else if (!is_old && !in_win) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        trig_pop  = 1'b0;
        pipe_pop  = 1'b0;
        ro_push   = 1'b0;
        ro_word   = '0;
        err_clear = 1'b0;
        ro_lost   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!trig_empty)                trig_pop = 1'b1;
                else if (!pipe_empty && is_old) pipe_pop = 1'b1;
            end
            ST_HEAD: begin
                if (!ro_full) begin
                    ro_push   = 1'b1;
                    ro_word   = {KIND_HDR, err_pending,
                                 {(CH_W + FINE_W - 1){1'b0}}, trig_q};
                    err_clear = 1'b1;
                end
            end
            ST_SCAN: begin
                if (!pipe_empty) begin
                    if (is_old) begin
                        pipe_pop = 1'b1;
                    end else if (in_win) begin
                        pipe_pop = 1'b1;
                        if (ro_full) begin
                            ro_lost = 1'b1;
                        end else begin
                            ro_push = 1'b1;
                            ro_word = {KIND_DATA, pipe_head};
                        end
                    end
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tdc_trigmatch_core.sv
module tdc_trigmatch_core #(
    parameter int NUM_CH      = 24,
    parameter int COARSE_W    = 13,
    parameter int FINE_W      = 4,
    parameter int CHBUF_DEPTH = 4,
    parameter int PIPE_DEPTH  = 256,
    parameter int TRIG_DEPTH  = 8,
    parameter int RO_DEPTH    = 64,
    localparam int CH_W       = $clog2(NUM_CH),
    localparam int STAMP_W    = COARSE_W + FINE_W,
    localparam int PIPE_W     = CH_W + STAMP_W,
    localparam int OUT_W      = 2 + PIPE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          hit_in,
    input  logic [NUM_CH*FINE_W-1:0]   fine_in,
    input  logic                       l1_trig,
    input  logic [COARSE_W-1:0]        win_lat,
    input  logic [COARSE_W-1:0]        win_width,
    input  logic                       rd_ready,
    output logic                       rd_valid,
    output logic [OUT_W-1:0]           rd_data
);
    logic [COARSE_W-1:0] coarse_q;
    logic [STAMP_W-1:0]  ch_dout [NUM_CH];
    logic [NUM_CH-1:0]   ch_empty;
    logic [NUM_CH-1:0]   ch_full;
    logic [NUM_CH-1:0]   ch_grant;
    logic [CH_W-1:0]     grant_idx;
    logic                grant_any;
    logic                ch_lost;
    logic                chbuf_busy;
    logic                pipe_empty;
    logic                pipe_full;
    logic                pipe_pop;
    logic [PIPE_W-1:0]   pipe_head;
    logic                trig_empty;
    logic                trig_full;
    logic                trig_pop;
    logic [COARSE_W-1:0] trig_time;
    logic                trig_lost;
    logic                ro_empty;
    logic                ro_full;
    logic                ro_push;
    logic [OUT_W-1:0]    ro_word;
    logic                ro_lost;
    logic                err_clear;
    logic                err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) coarse_q <= '0;
        else        coarse_q <= coarse_q + 1'b1;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        tdc_sync_fifo #(.WIDTH(STAMP_W), .DEPTH(CHBUF_DEPTH)) u_chbuf (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (hit_in[c]),
            .din   ({coarse_q, fine_in[c*FINE_W +: FINE_W]}),
            .pop   (ch_grant[c]),
            .dout  (ch_dout[c]),
            .empty (ch_empty[c]),
            .full  (ch_full[c])
        );
    end

    assign ch_lost    = |(hit_in & ch_full);
    assign chbuf_busy = ~&ch_empty;

    tdc_prio_arb #(.N(NUM_CH), .IW(CH_W)) u_arb (
        .req   (~ch_empty),
        .en    (~pipe_full),
        .grant (ch_grant),
        .idx   (grant_idx),
        .any   (grant_any)
    );

    tdc_sync_fifo #(.WIDTH(PIPE_W), .DEPTH(PIPE_DEPTH)) u_pipe (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (grant_any),
        .din   ({grant_idx, ch_dout[grant_idx]}),
        .pop   (pipe_pop),
        .dout  (pipe_head),
        .empty (pipe_empty),
        .full  (pipe_full)
    );

    tdc_sync_fifo #(.WIDTH(COARSE_W), .DEPTH(TRIG_DEPTH)) u_trigq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (l1_trig),
        .din   (coarse_q),
        .pop   (trig_pop),
        .dout  (trig_time),
        .empty (trig_empty),
        .full  (trig_full)
    );

    assign trig_lost = l1_trig & trig_full;

    tdc_match_fsm #(.CH_W(CH_W), .COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .now         (coarse_q),
        .win_lat     (win_lat),
        .win_width   (win_width),
        .trig_empty  (trig_empty),
        .trig_time   (trig_time),
        .trig_pop    (trig_pop),
        .pipe_empty  (pipe_empty),
        .pipe_head   (pipe_head),
        .pipe_pop    (pipe_pop),
        .chbuf_busy  (chbuf_busy),
        .ro_full     (ro_full),
        .err_pending (err_q),
        .ro_push     (ro_push),
        .ro_word     (ro_word),
        .err_clear   (err_clear),
        .ro_lost     (ro_lost)
    );

    tdc_sync_fifo #(.WIDTH(OUT_W), .DEPTH(RO_DEPTH)) u_rofifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ro_push),
        .din   (ro_word),
        .pop   (rd_ready),
        .dout  (rd_data),
        .empty (ro_empty),
        .full  (ro_full)
    );

    assign rd_valid = ~ro_empty;

    // sticky loss flag: a loss in the same cycle as a header survives the clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (err_q & ~err_clear) | ch_lost | trig_lost | ro_lost;
    end

endmodule

// File: rtl/tdc_trigmatch_chk.sv
module tdc_trigmatch_chk
    import tdc_pkg::*;
#(
    parameter int NUM_CH = 24,
    parameter int CH_W   = 5,
    parameter int OUT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] hit_in,
    input logic [NUM_CH-1:0] ch_full,
    input logic [NUM_CH-1:0] ch_grant,
    input logic              l1_trig,
    input logic              trig_full,
    input logic              ro_lost,
    input logic              err_q,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [OUT_W-1:0]  rd_data
);
    p_rst_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rd_valid);

    p_head_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    p_kind_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[OUT_W-1 -: 2] == KIND_HDR ||
                      rd_data[OUT_W-1 -: 2] == KIND_DATA));

    p_chan_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_data[OUT_W-1 -: 2] == KIND_DATA
            |-> 32'(rd_data[OUT_W-3 -: CH_W]) < NUM_CH);

    p_hit_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        |(hit_in & ch_full) |=> err_q);

    p_trig_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        l1_trig && trig_full |=> err_q);

    p_ro_loss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ro_lost |=> err_q);

    p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_grant));

endmodule

bind tdc_trigmatch_core tdc_trigmatch_chk #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .OUT_W  (OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_in    (hit_in),
    .ch_full   (ch_full),
    .ch_grant  (ch_grant),
    .l1_trig   (l1_trig),
    .trig_full (trig_full),
    .ro_lost   (ro_lost),
    .err_q     (err_q),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data)
);

// File: tb/tdc_trigmatch_core_test.sv
module tdc_trigmatch_core_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 24;
    localparam int FINE_W     = 4;
    localparam int COARSE_W   = 13;
    localparam int OUT_W      = 24;
    localparam int LAT        = 8;
    localparam int WID        = 8;
    localparam int NVEC       = 8;

    // {channel[4:0], fine[3:0], hit-to-trigger cycles[7:0], expect match}
    localparam logic [17:0] VEC [NVEC] = '{
        {5'd0,  4'd1,  8'd8,  1'b1},
        {5'd23, 4'd15, 8'd15, 1'b1},
        {5'd7,  4'd0,  8'd7,  1'b0},
        {5'd12, 4'd9,  8'd16, 1'b0},
        {5'd4,  4'd5,  8'd11, 1'b1},
        {5'd19, 4'd3,  8'd3,  1'b0},
        {5'd1,  4'd14, 8'd25, 1'b0},
        {5'd9,  4'd6,  8'd12, 1'b1}
    };

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic [NUM_CH-1:0]        hit_in = '0;
    logic [NUM_CH*FINE_W-1:0] fine_in = '0;
    logic                     l1_trig = 1'b0;
    logic [COARSE_W-1:0]      win_lat = COARSE_W'(LAT);
    logic [COARSE_W-1:0]      win_width = COARSE_W'(WID);
    logic                     rd_ready = 1'b0;
    logic                     rd_valid;
    logic [OUT_W-1:0]         rd_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int ngot = 0;
    logic [OUT_W-1:0] got [128];

    tdc_trigmatch_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_in    (hit_in),
        .fine_in   (fine_in),
        .l1_trig   (l1_trig),
        .win_lat   (win_lat),
        .win_width (win_width),
        .rd_ready  (rd_ready),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drain(input int n);
        ngot = 0;
        rd_ready = 1'b1;
        repeat (n) begin
            if (rd_valid) begin
                if (ngot < 128) got[ngot] = rd_data;
                ngot++;
            end
            @(negedge clk);
        end
        rd_ready = 1'b0;
    endtask

    task automatic trig_pulse();
        l1_trig = 1'b1;
        @(negedge clk);
        l1_trig = 1'b0;
    endtask

    task automatic hit_pulse(input logic [NUM_CH-1:0] m);
        hit_in = m;
        @(negedge clk);
        hit_in = '0;
    endtask

    function automatic logic [12:0] age_of(input logic [OUT_W-1:0] h,
                                           input logic [OUT_W-1:0] d);
        return h[12:0] - d[16:4];
    endfunction

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R11", "rd_valid after reset", rd_valid, 0);

        // table walk: window boundaries and field placement
        for (int v = 0; v < NVEC; v++) begin
            logic [4:0] ch;
            logic [3:0] fn;
            int         n;
            logic       ex;
            ch = VEC[v][17:13];
            fn = VEC[v][12:9];
            n  = int'(VEC[v][8:1]);
            ex = VEC[v][0];
            fine_in[ch*FINE_W +: FINE_W] = fn;
            hit_pulse(NUM_CH'(1) << ch);
            repeat (n - 1) @(negedge clk);
            trig_pulse();
            drain(40);
            chk(ngot == 1 + int'(ex), ex ? "R3" : "R4", "word count", ngot, 1 + int'(ex));
            chk(got[0][23:22] == 2'b10 && got[0][21] == 1'b0 && got[0][20:13] == '0,
                "R2", "header form", got[0][23:13], 12'h400);
            if (ex && ngot == 2) begin
                chk(got[1][23:22] == 2'b01, "R1", "data kind", got[1][23:22], 1);
                chk(got[1][21:17] == ch, "R1", "channel", got[1][21:17], ch);
                chk(got[1][3:0] == fn, "R1", "fine code", got[1][3:0], fn);
                chk(age_of(got[0], got[1]) == 13'(n), "R3", "age", age_of(got[0], got[1]), n);
            end
        end

        // same-edge hits leave lowest channel first
        hit_pulse((NUM_CH'(1) << 17) | (NUM_CH'(1) << 5) | (NUM_CH'(1) << 2));
        repeat (9) @(negedge clk);
        trig_pulse();
        drain(40);
        chk(ngot == 4, "R7", "word count", ngot, 4);
        chk(got[1][21:17] == 5'd2, "R7", "first channel", got[1][21:17], 2);
        chk(got[2][21:17] == 5'd5, "R7", "second channel", got[2][21:17], 5);
        chk(got[3][21:17] == 5'd17, "R7", "third channel", got[3][21:17], 17);

        // too-recent stamp kept for a later trigger
        fine_in[6*FINE_W +: FINE_W] = 4'd10;
        hit_pulse(NUM_CH'(1) << 6);
        repeat (3) @(negedge clk);
        trig_pulse();
        repeat (7) @(negedge clk);
        trig_pulse();
        drain(40);
        chk(ngot == 3, "R5", "word count", ngot, 3);
        chk(got[0][23:22] == 2'b10 && got[1][23:22] == 2'b10, "R12", "two headers first",
            {got[0][23:22], got[1][23:22]}, 4'b1010);
        chk(got[2][23:22] == 2'b01 && got[2][21:17] == 5'd6, "R5", "late data channel",
            got[2][21:17], 6);
        chk(age_of(got[1], got[2]) == 13'd12, "R5", "age vs second trigger",
            age_of(got[1], got[2]), 12);

        // channel queue overrun
        hit_in = '1;
        repeat (6) @(negedge clk);
        hit_in = '0;
        repeat (300) @(negedge clk);
        trig_pulse();
        drain(30);
        chk(ngot == 1, "R8", "stale flood not output", ngot, 1);
        chk(got[0][21] == 1'b1, "R8", "error reported", got[0][21], 1);
        trig_pulse();
        drain(30);
        chk(got[0][21] == 1'b0, "R8", "error cleared", got[0][21], 0);

        // trigger queue overrun
        l1_trig = 1'b1;
        repeat (16) @(negedge clk);
        l1_trig = 1'b0;
        repeat (80) @(negedge clk);
        drain(60);
        chk(ngot >= 9 && ngot < 16, "R9", "accepted triggers", ngot, 13);
        begin
            int nerr;
            nerr = 0;
            for (int i = 0; i < ngot && i < 128; i++) if (got[i][21]) nerr++;
            chk(nerr > 0, "R9", "error headers", nerr, 1);
        end
        trig_pulse();
        drain(30);
        chk(ngot == 1 && got[0][21] == 1'b0, "R9", "clean header after", got[0][21], 0);

        // readout overrun: 72 matched stamps, 64 slots
        hit_in = '1;
        repeat (3) @(negedge clk);
        hit_in = '0;
        repeat (7) @(negedge clk);
        trig_pulse();
        repeat (200) @(negedge clk);
        chk(rd_valid == 1'b1, "R10", "head held while not ready", rd_valid, 1);
        drain(120);
        chk(ngot == 64, "R10", "readout words", ngot, 64);
        chk(got[0][23:22] == 2'b10, "R12", "header first", got[0][23:22], 2);
        trig_pulse();
        drain(30);
        chk(ngot == 1 && got[0][21] == 1'b1, "R10", "loss reported", got[0][21], 1);

        // window across counter wraparound
        begin
            int b0;
            int d;
            logic [12:0] t0;
            b0 = cyc;
            trig_pulse();
            drain(20);
            t0 = got[0][12:0];
            d = (8189 - int'(t0) + 8192) % 8192;
            if (d < 60) d += 8192;
            while (cyc < b0 + d) @(negedge clk);
            fine_in[11*FINE_W +: FINE_W] = 4'd7;
            hit_pulse(NUM_CH'(1) << 11);
            repeat (9) @(negedge clk);
            trig_pulse();
            drain(40);
            chk(ngot == 2, "R6", "word count", ngot, 2);
            chk(got[1][16:4] == 13'd8189, "R6", "stamp before wrap", got[1][16:4], 8189);
            chk(got[0][12:0] == 13'd7, "R6", "trigger after wrap", got[0][12:0], 7);
            chk(got[1][21:17] == 5'd11 && got[1][3:0] == 4'd7, "R1", "wrap data fields",
                got[1][21:0] >> 17, 11);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule